// File: doc/BRIEF.md
# Funnel Shift Unit

This block forms one result word from a two-word funnel. The high word `src_hi` sits above the low word `src_lo`. The pair is shifted left or right by an amount, and one word-wide slice of the shifted value is returned. A left shift yields the upper slice and a right shift yields the lower slice. A range control selects either a one-word range or a two-word range. In the two-word range, a right shift can fill with the sign of the high word.

Two policies handle an amount that is too large. With masking enabled, the amount is wrapped to the range. With masking disabled, the result is forced to zero. The amount comes from a full-width operand or from a 6-bit immediate. Zero and negative flags can be produced alongside the result.

All outputs are registered once behind a valid strobe. A result is therefore delivered one clock after its operands are accepted. The unit sits inside an integer datapath.

Top module: `funnel_shift_unit`

## Requirements
- R1: Left shift (`dir_left`=1) with effective amount B below the word width W gives (hi << B) | (lo >> (W−B)); with B = 0 the result is exactly `src_hi`.
- R2: Right shift (`dir_left`=0) with B below W gives (lo >> B) | (hi << (W−B)); with B = 0 the result is exactly `src_lo`.
- R3: In a two-word range (`range_sel` 1 or 2), a left shift with B ≥ W gives lo << (B−W).
- R4: In a two-word range, a right shift with B ≥ W gives hi >> (B−W). The shift is logical for `range_sel`=1 and arithmetic, filling with bit W−1 of `src_hi`, for `range_sel`=2.
- R5: With `mask_en`=1, the amount is ANDed with W−1 in the one-word range (`range_sel` 0) and with 2W−1 in a two-word range.
- R6: With `mask_en`=0, an amount of at least W (one-word range) or 2W (two-word range) forces the result to zero. This holds in the signed mode as well.
- R7: `use_imm`=1 takes the amount from `amt_imm`, zero-extended. `use_imm`=0 takes the amount from all W bits of `amt_reg`.
- R8: For an accepted operation with `wr_cc`=1, `cc_upd` is 1, `flag_z` is 1 exactly when the result is zero, and `flag_n` equals result bit W−1. With `wr_cc`=0, all three outputs are 0.
- R9: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid`=1. `result` and the flags belong to that operation.
- R10: While `in_valid`=0, `result`, `flag_z`, `flag_n` and `cc_upd` hold their values regardless of the other inputs.
- R11: After reset, `out_valid`, `result`, `flag_z`, `flag_n` and `cc_upd` are all 0.
- R12: `range_sel`=3 behaves exactly like the one-word range (`range_sel`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented this cycle |
| dir_left | input | 1 | 1 = left funnel, 0 = right funnel |
| range_sel | input | 2 | 0/3 one-word, 1 two-word unsigned, 2 two-word signed |
| mask_en | input | 1 | 1 = wrap amount, 0 = zero result on overflow |
| wr_cc | input | 1 | Produce flags for this operation |
| use_imm | input | 1 | Amount source select |
| amt_reg | input | W | Full-width shift amount |
| amt_imm | input | 6 | Immediate shift amount |
| src_lo | input | W | Low word of the funnel |
| src_hi | input | W | High word of the funnel |
| out_valid | output | 1 | Result of last cycle's operation is present |
| result | output | W | Selected word of the shifted pair |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result sign bit |
| cc_upd | output | 1 | Flags were written by this operation |

## Verification
Every output is due exactly one clock after the cycle that carries `in_valid`. There is a single register between the operands and the ports. The bench drives each operation on a falling edge and reads the result, the flags and `out_valid` on the next falling edge, half a period after the capturing rising edge. For the hold behaviour, `in_valid` stays low for two full cycles while the operand inputs change. The held values are then compared with those captured before.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
    typedef enum logic [1:0] {
        RNG_ONE  = 2'd0,
        RNG_U2W  = 2'd1,
        RNG_S2W  = 2'd2,
        RNG_ALT  = 2'd3
    } fsu_range_e;

    function automatic logic range_is_wide(input fsu_range_e r);
        return (r == RNG_U2W) || (r == RNG_S2W);
    endfunction
endpackage

// File: rtl/fsu_amount.sv
module fsu_amount #(
    parameter int W     = 32,
    parameter int IMM_W = 6,
    localparam int SH_W = $clog2(2 * W)
) (
    input  logic             wide,
    input  logic             mask_en,
    input  logic             use_imm,
    input  logic [W-1:0]     amt_reg,
    input  logic [IMM_W-1:0] amt_imm,
    output logic [SH_W-1:0]  amt_eff,
    output logic             amt_ovf
);
    localparam logic [W-1:0] LIM_ONE = W[W-1:0];
    localparam logic [W-1:0] LIM_TWO = (2 * W);

    logic [W-1:0] raw;
    logic [W-1:0] lim;
    logic [W-1:0] wrapped;

    always_comb begin
        raw     = use_imm ? {{(W-IMM_W){1'b0}}, amt_imm} : amt_reg;
        lim     = wide ? LIM_TWO : LIM_ONE;
        wrapped = raw & (lim - 1'b1);
        if (mask_en) begin
            amt_eff = wrapped[SH_W-1:0];
            amt_ovf = 1'b0;
        end else begin
            amt_eff = raw[SH_W-1:0];
            amt_ovf = (raw >= lim);
        end
    end
endmodule

// File: rtl/fsu_funnel.sv
module fsu_funnel #(
    parameter int W     = 32,
    localparam int SH_W = $clog2(2 * W)
) (
    input  logic            left,
    input  logic            sign_fill,
    input  logic [W-1:0]    lo,
    input  logic [W-1:0]    hi,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    word
);
    logic [2*W-1:0] pair;
    logic           fill;

    assign pair = {hi, lo};
    assign fill = sign_fill & hi[W-1];

    always_comb begin
        for (int i = 0; i < W; i++) begin
            int idx;
            if (left) begin
                idx = i + W - int'(amt);
                word[i] = (idx >= 0) ? pair[idx] : 1'b0;
            end else begin
                idx = i + int'(amt);
                word[i] = (idx < 2 * W) ? pair[idx] : fill;
            end
        end
    end
endmodule

// File: rtl/fsu_flags.sv
module fsu_flags #(
    parameter int W = 32
) (
    input  logic         enable,
    input  logic [W-1:0] word,
    output logic         zero,
    output logic         neg
);
    assign zero = enable & ~(|word);
    assign neg  = enable & word[W-1];
endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit #(
    parameter int W     = 32,
    parameter int IMM_W = 6,
    localparam int SH_W = $clog2(2 * W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             dir_left,
    input  logic [1:0]       range_sel,
    input  logic             mask_en,
    input  logic             wr_cc,
    input  logic             use_imm,
    input  logic [W-1:0]     amt_reg,
    input  logic [IMM_W-1:0] amt_imm,
    input  logic [W-1:0]     src_lo,
    input  logic [W-1:0]     src_hi,
    output logic             out_valid,
    output logic [W-1:0]     result,
    output logic             flag_z,
    output logic             flag_n,
    output logic             cc_upd
);
    import fsu_pkg::*;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         z;
        logic         n;
        logic         cc;
    } stage_t;

    stage_t     st_d, st_q;
    fsu_range_e rng;
    logic       wide;
    logic [SH_W-1:0] amt_eff;
    logic       amt_ovf;
    logic [W-1:0] shifted;
    logic [W-1:0] res_c;
    logic       z_c, n_c;

    assign rng  = fsu_range_e'(range_sel);
    assign wide = range_is_wide(rng);

    fsu_amount #(.W(W), .IMM_W(IMM_W)) u_amt (
        .wide    (wide),
        .mask_en (mask_en),
        .use_imm (use_imm),
        .amt_reg (amt_reg),
        .amt_imm (amt_imm),
        .amt_eff (amt_eff),
        .amt_ovf (amt_ovf)
    );

    fsu_funnel #(.W(W)) u_fun (
        .left      (dir_left),
        .sign_fill (rng == RNG_S2W),
        .lo        (src_lo),
        .hi        (src_hi),
        .amt       (amt_eff),
        .word      (shifted)
    );

    assign res_c = amt_ovf ? '0 : shifted;

    fsu_flags #(.W(W)) u_flg (
        .enable (wr_cc),
        .word   (res_c),
        .zero   (z_c),
        .neg    (n_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = res_c;
            st_d.z   = z_c;
            st_d.n   = n_c;
            st_d.cc  = wr_cc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign flag_z    = st_q.z;
    assign flag_n    = st_q.n;
    assign cc_upd    = st_q.cc;
endmodule

// File: rtl/fsu_chk.sv
module fsu_chk #(
    parameter int W     = 32,
    parameter int IMM_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             dir_left,
    input logic             mask_en,
    input logic             use_imm,
    input logic [W-1:0]     amt_reg,
    input logic [W-1:0]     src_lo,
    input logic             out_valid,
    input logic [W-1:0]     result,
    input logic             flag_z,
    input logic             flag_n,
    input logic             cc_upd
);
    localparam logic [W-1:0] TWO_W = (2 * W);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(flag_z) && $stable(cc_upd));
    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cc_upd) |-> (flag_z == (result == '0)) && (flag_n == result[W-1]));
    // R8
    no_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_upd |-> !flag_z && !flag_n);
    // R6
    clamp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_en && !use_imm && amt_reg >= TWO_W) |=> result == '0);
    // R2
    right_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir_left && !use_imm && amt_reg == '0) |=> result == $past(src_lo));
endmodule

bind funnel_shift_unit fsu_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .dir_left  (dir_left),
    .mask_en   (mask_en),
    .use_imm   (use_imm),
    .amt_reg   (amt_reg),
    .src_lo    (src_lo),
    .out_valid (out_valid),
    .result    (result),
    .flag_z    (flag_z),
    .flag_n    (flag_n),
    .cc_upd    (cc_upd)
);

// File: tb/sim_funnel_shift_unit.sv
module sim_funnel_shift_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dir_left = 1'b0;
    logic [1:0]  range_sel = 2'd0;
    logic        mask_en = 1'b0;
    logic        wr_cc = 1'b0;
    logic        use_imm = 1'b0;
    logic [31:0] amt_reg = '0;
    logic [5:0]  amt_imm = '0;
    logic [31:0] src_lo = '0;
    logic [31:0] src_hi = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_z, flag_n, cc_upd;

    int n_run = 0;
    int n_fail = 0;

    always #5ns clk = ~clk;

    funnel_shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_left(dir_left),
        .range_sel(range_sel), .mask_en(mask_en), .wr_cc(wr_cc), .use_imm(use_imm),
        .amt_reg(amt_reg), .amt_imm(amt_imm), .src_lo(src_lo), .src_hi(src_hi),
        .out_valid(out_valid), .result(result), .flag_z(flag_z), .flag_n(flag_n),
        .cc_upd(cc_upd)
    );

    function automatic logic [31:0] model(input logic l, input logic [1:0] rg,
                                          input logic m, input logic [31:0] a,
                                          input logic [31:0] c, input logic [31:0] b_in);
        logic        two;
        logic [31:0] lim, b;
        two = (rg == 2'd1) || (rg == 2'd2);
        lim = two ? 32'd64 : 32'd32;
        b   = b_in;
        if (m) b = b & (lim - 1);
        else if (b >= lim) return 32'd0;
        if (l) begin
            if (b >= 32) return a << (b - 32);
            if (b == 0) return c;
            return (c << b) | (a >> (32 - b));
        end
        if (b >= 32) begin
            if (rg == 2'd2) return $signed(c) >>> (b - 32);
            return c >> (b - 32);
        end
        if (b == 0) return a;
        return (a >> b) | (c << (32 - b));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_for(input logic l, input logic [1:0] rg, input logic m,
                                      input logic [31:0] b);
        logic two;
        two = (rg == 2'd1) || (rg == 2'd2);
        if (rg == 2'd3) return "R12";
        if (m && (b >= (two ? 64 : 32))) return "R5";
        if (!m && (b >= (two ? 64 : 32))) return "R6";
        if (b >= 32) return l ? "R3" : "R4";
        return l ? "R1" : "R2";
    endfunction

    task automatic do_op(input logic l, input logic [1:0] rg, input logic m, input logic cc,
                         input logic imm, input logic [31:0] breg, input logic [5:0] bimm,
                         input logic [31:0] a, input logic [31:0] c);
        logic [31:0] exp;
        string t;
        in_valid = 1'b1; dir_left = l; range_sel = rg; mask_en = m; wr_cc = cc;
        use_imm = imm; amt_reg = breg; amt_imm = bimm; src_lo = a; src_hi = c;
        exp = model(l, rg, m, a, c, imm ? {26'd0, bimm} : breg);
        t = imm ? "R7" : tag_for(l, rg, m, breg);
        @(negedge clk);
        check(t, result, exp);
        check("R9", {31'd0, out_valid}, 32'd1);
        check("R8", {29'd0, cc_upd, flag_z, flag_n},
              cc ? {29'd0, 1'b1, exp == 0, exp[31]} : 32'd0);
    endtask

    initial begin
        #1500us;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] los [4];
        logic [31:0] his [4];
        logic [31:0] big [4];
        logic [31:0] keep;
        los = '{32'h89AB_CDEF, 32'h0000_0001, 32'hFFFF_FFFF, 32'h1234_5678};
        his = '{32'h0123_4567, 32'h8000_0000, 32'hF0F0_0F0F, 32'h7FFF_FFFE};
        big = '{32'd255, 32'hFFFF_FFFF, 32'h0001_0021, 32'h8000_0000};
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", {27'd0, out_valid, flag_z, flag_n, cc_upd, |result}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", {31'd0, out_valid}, 32'd0);

        for (int l = 0; l < 2; l++)
            for (int rg = 0; rg < 4; rg++)
                for (int m = 0; m < 2; m++)
                    for (int p = 0; p < 4; p++) begin
                        for (int b = 0; b <= 70; b++)
                            do_op(l[0], rg[1:0], m[0], b[0], 1'b0, b, 6'd0, los[p], his[p]);
                        for (int k = 0; k < 4; k++)
                            do_op(l[0], rg[1:0], m[0], 1'b1, 1'b0, big[k], 6'd0, los[p], his[p]);
                    end

        // R7: immediate source, register amount would otherwise clamp
        for (int l = 0; l < 2; l++)
            for (int rg = 0; rg < 3; rg++)
                for (int b = 0; b < 64; b++)
                    do_op(l[0], rg[1:0], 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, b[5:0],
                          32'hC3A5_5A3C, 32'h9E37_79B9);

        // R10: idle cycles leave outputs held
        do_op(1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 32'd40, 6'd0, 32'h0, 32'h8000_1234);
        keep = result;
        in_valid = 1'b0; src_lo = 32'h5555_5555; src_hi = 32'hAAAA_AAAA;
        amt_reg = 32'd3; wr_cc = 1'b0; dir_left = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10", result, keep);
        check("R10", {30'd0, cc_upd, out_valid}, 32'd2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule